// File: doc/BRIEF.md
# Interrupt Status Aggregation Controller

This block keeps one status word of pending interrupt causes for a device. Software and two internal completion sources set bits in it. A separate acknowledge strobe with a bit mask clears bits. From changes to the word it produces one of two notifications:
- a level-sensitive legacy interrupt line, or
- a single-cycle message notification pulse while message mode is on.

The message pulse goes to the logic that issues the message write. Address decoding and the write transaction itself are outside this block.

The two modes treat set and clear events differently:
- In legacy mode, any set event that leaves the word nonzero drives the line high. An acknowledge drops the line only when it empties the word.
- In message mode, every set event that leaves the word nonzero sends a pulse. This includes set events for bits that are already pending.
- While message mode is on, the legacy line is never changed. A level raised earlier therefore survives acknowledges made while message mode is on.

A set event and an acknowledge in the same cycle are merged with the clear applied first. A bit raised in that cycle is therefore always kept.

Top module: `intr_status_aggr`

## Requirements
- R1: While reset is held, and in the first cycle after its synchronized release, the status word, `irq_level` and `msi_pulse` are all zero.
- R2: When `raise_vld` is high, `raise_mask` is ORed into the status word. The new value appears on `status` one clock edge later.
- R3: When `ack_vld` is high, exactly the bits that are 1 in `ack_mask` are cleared. Every other bit keeps its value.
- R4: A set event and an acknowledge in the same cycle give a new word of (old & ~ack_mask) | raised bits, so a bit present in both masks ends up set.
- R5: With `msi_en` low, a set event that leaves the word nonzero drives `irq_level` high from the next edge.
- R6: With `msi_en` high, a set event that leaves the word nonzero makes `msi_pulse` high for exactly one cycle after the edge and leaves `irq_level` unchanged. This also holds when the raised bits were already set.
- R7: With `msi_en` low and no set event, an acknowledge that leaves the word zero drops `irq_level`. An acknowledge that leaves any bit set keeps it high.
- R8: While `msi_en` is high, `irq_level` keeps its value across every edge, including acknowledges that empty the word.
- R9: A pulse on `evt_calc_done` acts as a set event for bit 0 (value 0x1). A pulse on `evt_xfer_done` acts as a set event for bit 8 (value 0x100).
- R10: A set event with an all-zero mask on an empty word changes neither output. `msi_pulse` is low after any cycle that had no set event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| raise_vld | input | 1 | Software set strobe |
| raise_mask | input | 32 | Bits to set |
| ack_vld | input | 1 | Acknowledge strobe |
| ack_mask | input | 32 | Bits to clear |
| evt_calc_done | input | 1 | Computation-done source, sets bit 0 |
| evt_xfer_done | input | 1 | Transfer-done source, sets bit 8 |
| msi_en | input | 1 | Message notification mode enable |
| status | output | 32 | Current status word (read port) |
| irq_level | output | 1 | Legacy level interrupt |
| msi_pulse | output | 1 | One-cycle message notification |

## Verification
The hardest case to reach from the ports is a legacy level that outlives an empty word. To get there, the line is raised with message mode off. Message mode is then turned on and the word is acknowledged down to zero, and the test shows the line stays high. Message mode is then turned off again and an acknowledge with an empty mask shows the line finally dropping. A second directed sequence drives a set event and an acknowledge with overlapping masks in the same cycle to show the clear-then-set order.

// File: rtl/intr_aggr_pkg.sv
package intr_aggr_pkg;

  // Action chosen by the notification controller for one cycle
  typedef enum logic [1:0] {
    ACT_HOLD    = 2'd0,
    ACT_ASSERT  = 2'd1,
    ACT_NOTIFY  = 2'd2,
    ACT_RELEASE = 2'd3
  } notify_act_e;

  // Pick the notification action from the set/clear events, the mode and
  // whether the word will be nonzero after this edge.
  function automatic notify_act_e pick_action(
    input logic set_evt,
    input logic clr_evt,
    input logic msg_mode,
    input logic nxt_nonzero
  );
    notify_act_e act;
    act = ACT_HOLD;
    if (set_evt && nxt_nonzero) begin
      act = msg_mode ? ACT_NOTIFY : ACT_ASSERT;
    end else if (clr_evt && !nxt_nonzero && !msg_mode) begin
      act = ACT_RELEASE;
    end
    return act;
  endfunction

endpackage

// File: rtl/intr_rst_sync.sv
module intr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] shreg_q;
  logic [STAGES-1:0] shreg_nxt;

  always_comb begin
    shreg_nxt = {shreg_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
    end else begin
      shreg_q <= shreg_nxt;
    end
  end

  assign rst_n_sync = shreg_q[STAGES-1];

endmodule

// File: rtl/intr_event_merge.sv
module intr_event_merge #(
  parameter int W        = 32,
  parameter int CALC_BIT = 0,
  parameter int XFER_BIT = 8
) (
  input  logic         raise_vld,
  input  logic [W-1:0] raise_mask,
  input  logic         evt_calc_done,
  input  logic         evt_xfer_done,
  output logic         set_vld,
  output logic [W-1:0] set_mask
);

  // Each bit takes its software request, plus the matching internal source
  // if one is tied to that position.
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic sw_bit;
    logic src_bit;
    assign sw_bit = raise_vld & raise_mask[b];
    if (b == CALC_BIT) begin : g_calc
      assign src_bit = evt_calc_done;
    end else if (b == XFER_BIT) begin : g_xfer
      assign src_bit = evt_xfer_done;
    end else begin : g_none
      assign src_bit = 1'b0;
    end
    assign set_mask[b] = sw_bit | src_bit;
  end

  assign set_vld = raise_vld | evt_calc_done | evt_xfer_done;

endmodule

// File: rtl/intr_status_word.sv
module intr_status_word #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_vld,
  input  logic [W-1:0] set_mask,
  input  logic         clr_vld,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] status_q,
  output logic         nxt_nonzero
);

  logic [W-1:0] status_nxt;
  logic         upd_en;

  // Clear first, then set, so a bit raised in this cycle is kept
  for (genvar b = 0; b < W; b++) begin : g_cell
    logic kept;
    assign kept          = status_q[b] & ~(clr_vld & clr_mask[b]);
    assign status_nxt[b] = kept | (set_vld & set_mask[b]);
  end

  assign upd_en      = set_vld | clr_vld;
  assign nxt_nonzero = |status_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
    end else if (upd_en) begin
      status_q <= status_nxt;
    end
  end

endmodule

// File: rtl/intr_notify_ctrl.sv
module intr_notify_ctrl
  import intr_aggr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set_vld,
  input  logic clr_vld,
  input  logic msi_en,
  input  logic nxt_nonzero,
  output logic irq_level,
  output logic msi_pulse
);

  notify_act_e act;
  logic        level_nxt;
  logic        level_en;
  logic        pulse_nxt;

  always_comb begin
    act       = pick_action(set_vld, clr_vld, msi_en, nxt_nonzero);
    level_en  = 1'b0;
    level_nxt = irq_level;
    pulse_nxt = 1'b0;
    unique case (act)
      ACT_ASSERT: begin
        level_en  = 1'b1;
        level_nxt = 1'b1;
      end
      ACT_RELEASE: begin
        level_en  = 1'b1;
        level_nxt = 1'b0;
      end
      ACT_NOTIFY: pulse_nxt = 1'b1;
      default:    pulse_nxt = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_level <= 1'b0;
    end else if (level_en) begin
      irq_level <= level_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msi_pulse <= 1'b0;
    end else begin
      msi_pulse <= pulse_nxt;
    end
  end

endmodule

// File: rtl/intr_status_aggr.sv
module intr_status_aggr #(
  parameter int W        = 32,
  parameter int CALC_BIT = 0,
  parameter int XFER_BIT = 8,
  parameter int SYNC_STG = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         raise_vld,
  input  logic [W-1:0] raise_mask,
  input  logic         ack_vld,
  input  logic [W-1:0] ack_mask,
  input  logic         evt_calc_done,
  input  logic         evt_xfer_done,
  input  logic         msi_en,
  output logic [W-1:0] status,
  output logic         irq_level,
  output logic         msi_pulse
);

  logic         rst_n_int;
  logic         set_vld;
  logic [W-1:0] set_mask;
  logic         nxt_nonzero;

  intr_rst_sync #(.STAGES(SYNC_STG)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  intr_event_merge #(.W(W), .CALC_BIT(CALC_BIT), .XFER_BIT(XFER_BIT)) u_merge (
    .raise_vld     (raise_vld),
    .raise_mask    (raise_mask),
    .evt_calc_done (evt_calc_done),
    .evt_xfer_done (evt_xfer_done),
    .set_vld       (set_vld),
    .set_mask      (set_mask)
  );

  intr_status_word #(.W(W)) u_word (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .set_vld     (set_vld),
    .set_mask    (set_mask),
    .clr_vld     (ack_vld),
    .clr_mask    (ack_mask),
    .status_q    (status),
    .nxt_nonzero (nxt_nonzero)
  );

  intr_notify_ctrl u_notify (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .set_vld     (set_vld),
    .clr_vld     (ack_vld),
    .msi_en      (msi_en),
    .nxt_nonzero (nxt_nonzero),
    .irq_level   (irq_level),
    .msi_pulse   (msi_pulse)
  );

endmodule

// File: rtl/intr_status_aggr_chk.sv
module intr_status_aggr_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         raise_vld,
  input logic [W-1:0] raise_mask,
  input logic         ack_vld,
  input logic [W-1:0] ack_mask,
  input logic         evt_calc_done,
  input logic         evt_xfer_done,
  input logic         msi_en,
  input logic [W-1:0] status,
  input logic         irq_level,
  input logic         msi_pulse
);

  logic any_set;
  assign any_set = raise_vld | evt_calc_done | evt_xfer_done;

  // R2
  raise_sets_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    raise_vld |=> ((status & $past(raise_mask)) == $past(raise_mask)));

  // R3
  ack_clears_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_vld && !any_set) |=> (status == ($past(status) & ~$past(ack_mask))));

  // R6
  msg_pulse_on_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (raise_vld && msi_en && (raise_mask != '0)) |=> msi_pulse);

  // R7
  legacy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_vld && !any_set && !msi_en && ((status & ~ack_mask) == '0)) |=> !irq_level);

  // R8
  msg_mode_level_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msi_en |=> $stable(irq_level));

  // R10
  no_pulse_without_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !any_set |=> !msi_pulse);

endmodule

bind intr_status_aggr intr_status_aggr_chk #(.W(W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .raise_vld     (raise_vld),
  .raise_mask    (raise_mask),
  .ack_vld       (ack_vld),
  .ack_mask      (ack_mask),
  .evt_calc_done (evt_calc_done),
  .evt_xfer_done (evt_xfer_done),
  .msi_en        (msi_en),
  .status        (status),
  .irq_level     (irq_level),
  .msi_pulse     (msi_pulse)
);

// File: tb/intr_status_aggr_bench.sv
module intr_status_aggr_bench;

  logic        clk;
  logic        rst_n;
  logic        raise_vld;
  logic [31:0] raise_mask;
  logic        ack_vld;
  logic [31:0] ack_mask;
  logic        evt_calc_done;
  logic        evt_xfer_done;
  logic        msi_en;
  logic [31:0] status;
  logic        irq_level;
  logic        msi_pulse;

  int n_chk;
  int n_bad;

  intr_status_aggr u_intr_status_aggr (
    .clk           (clk),
    .rst_n         (rst_n),
    .raise_vld     (raise_vld),
    .raise_mask    (raise_mask),
    .ack_vld       (ack_vld),
    .ack_mask      (ack_mask),
    .evt_calc_done (evt_calc_done),
    .evt_xfer_done (evt_xfer_done),
    .msi_en        (msi_en),
    .status        (status),
    .irq_level     (irq_level),
    .msi_pulse     (msi_pulse)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic chk_all(input string req, input logic [31:0] s, input logic irq, input logic msi);
    chk({req, " status"}, status, s);
    chk({req, " irq_level"}, {31'd0, irq_level}, {31'd0, irq});
    chk({req, " msi_pulse"}, {31'd0, msi_pulse}, {31'd0, msi});
  endtask

  // Apply one cycle of stimulus, then sample 1 ns after the edge
  task automatic step(input logic rv, input logic [31:0] rm, input logic av,
                      input logic [31:0] am, input logic ec, input logic ex);
    raise_vld = rv; raise_mask = rm; ack_vld = av; ack_mask = am;
    evt_calc_done = ec; evt_xfer_done = ex;
    @(posedge clk); #1;
    raise_vld = 1'b0; raise_mask = '0; ack_vld = 1'b0; ack_mask = '0;
    evt_calc_done = 1'b0; evt_xfer_done = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; msi_en = 1'b0;
    raise_vld = 1'b0; raise_mask = '0; ack_vld = 1'b0; ack_mask = '0;
    evt_calc_done = 1'b0; evt_xfer_done = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk_all("R1 in reset", 32'h0, 1'b0, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk_all("R1 after release", 32'h0, 1'b0, 1'b0);
  endtask

  task automatic t_legacy_raise_ack();
    msi_en = 1'b0;
    step(1'b1, 32'h5, 1'b0, 32'h0, 1'b0, 1'b0);
    chk_all("R2 R5 first raise", 32'h5, 1'b1, 1'b0);
    step(1'b1, 32'h30, 1'b0, 32'h0, 1'b0, 1'b0);
    chk_all("R2 accumulate", 32'h35, 1'b1, 1'b0);
    step(1'b0, 32'h0, 1'b1, 32'h11, 1'b0, 1'b0);
    chk_all("R3 R7 partial ack", 32'h24, 1'b1, 1'b0);
    step(1'b0, 32'h0, 1'b1, 32'h24, 1'b0, 1'b0);
    chk_all("R7 ack to zero", 32'h0, 1'b0, 1'b0);
  endtask

  task automatic t_same_cycle();
    msi_en = 1'b0;
    step(1'b1, 32'h3, 1'b0, 32'h0, 1'b0, 1'b0);
    step(1'b1, 32'h2, 1'b1, 32'h3, 1'b0, 1'b0);
    chk_all("R4 clear then set", 32'h2, 1'b1, 1'b0);
    step(1'b0, 32'h0, 1'b1, 32'h2, 1'b0, 1'b0);
    chk_all("R4 cleanup", 32'h0, 1'b0, 1'b0);
  endtask

  task automatic t_msg_mode();
    msi_en = 1'b1;
    step(1'b1, 32'h80, 1'b0, 32'h0, 1'b0, 1'b0);
    chk_all("R6 pulse on raise", 32'h80, 1'b0, 1'b1);
    step(1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 1'b0);
    chk_all("R6 single cycle", 32'h80, 1'b0, 1'b0);
    step(1'b1, 32'h80, 1'b0, 32'h0, 1'b0, 1'b0);
    chk_all("R6 re-raise set bit", 32'h80, 1'b0, 1'b1);
    step(1'b0, 32'h0, 1'b1, 32'h80, 1'b0, 1'b0);
    chk_all("R6 ack no pulse", 32'h0, 1'b0, 1'b0);
    msi_en = 1'b0;
  endtask

  task automatic t_sticky_level();
    msi_en = 1'b0;
    step(1'b1, 32'h1, 1'b0, 32'h0, 1'b0, 1'b0);
    chk_all("R5 raise legacy", 32'h1, 1'b1, 1'b0);
    msi_en = 1'b1;
    step(1'b0, 32'h0, 1'b1, 32'h1, 1'b0, 1'b0);
    chk_all("R8 level kept in msg mode", 32'h0, 1'b1, 1'b0);
    msi_en = 1'b0;
    step(1'b0, 32'h0, 1'b1, 32'h0, 1'b0, 1'b0);
    chk_all("R7 empty ack drops level", 32'h0, 1'b0, 1'b0);
  endtask

  task automatic t_sources();
    msi_en = 1'b0;
    step(1'b0, 32'h0, 1'b0, 32'h0, 1'b1, 1'b0);
    chk_all("R9 calc source bit0", 32'h1, 1'b1, 1'b0);
    step(1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 1'b1);
    chk_all("R9 xfer source bit8", 32'h101, 1'b1, 1'b0);
    step(1'b0, 32'h0, 1'b1, 32'hFFFF_FFFF, 1'b0, 1'b0);
    chk_all("R9 cleanup", 32'h0, 1'b0, 1'b0);
  endtask

  task automatic t_zero_raise();
    msi_en = 1'b1;
    step(1'b1, 32'h0, 1'b0, 32'h0, 1'b0, 1'b0);
    chk_all("R10 zero raise msg mode", 32'h0, 1'b0, 1'b0);
    msi_en = 1'b0;
    step(1'b1, 32'h0, 1'b0, 32'h0, 1'b0, 1'b0);
    chk_all("R10 zero raise legacy", 32'h0, 1'b0, 1'b0);
  endtask

  initial begin
    n_chk = 0;
    n_bad = 0;
    t_reset();
    t_legacy_raise_ack();
    t_same_cycle();
    t_msg_mode();
    t_sticky_level();
    t_sources();
    t_zero_raise();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule